// File: doc/BRIEF.md
# Quadrature Encoder Step Selector

This block turns the two already-debounced contact lines of a rotary encoder into a small saturating setting in the range 0 to 6. The contacts are not watched on every clock: a down-counter driven by an external tick strobe lets the block look at them only once every 64 strobes. This slow look keeps contact chatter from being counted twice.

At each look the block treats a low level on the clock-phase contact (pin 0) as the start of a detent. An internal armed flag makes sure that one detent gives exactly one step. The flag is set when a step is taken and is cleared only when pin 0 is seen high again at a later look. The direction contact (pin 1) selects the direction of the step.

Whenever the setting really moves, the block raises a single-clock `changed` pulse. The filter that consumes the setting can use this pulse to clear its own history. A step that would carry the setting past either end is dropped silently.

Top module: `enc_step_select`

## Requirements
- R1: After synchronous reset, `setting` is 3 and `changed` is 0, and the armed flag is clear.
- R2: The pins are looked at only on the clock in which the 64th `tick` strobe since the previous look (or since reset) is high. Pin levels on any other clock, including clocks with `tick` low, do not change `setting` or `changed`.
- R3: A look that finds `pin0` = 1 clears the armed flag and does not change `setting`.
- R4: A look that finds `pin0` = 0 while the armed flag is set takes no step and leaves `setting` unchanged.
- R5: A look that finds `pin0` = 0 with the flag clear sets the flag. If `pin1` = 1 it also adds 1 to `setting`, unless `setting` is already 6 or more.
- R6: In the same case with `pin1` = 0, `setting` is reduced by 1, unless it is already 0.
- R7: `changed` is 1 for exactly one clock, in the clock in which a new `setting` value first appears. It stays 0 when a step is blocked at 0 or 6.
- R8: The tick counter reloads on the same clock as the look, so looks fall exactly 64 strobes apart whatever the spacing of the strobes.
- R9: `setting` never leaves the range 0 to 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Decimation strobe, one clock wide per tick |
| pin0 | input | 1 | Debounced clock-phase contact |
| pin1 | input | 1 | Debounced direction contact |
| setting | output | 3 | Current step setting, 0 to 6 |
| changed | output | 1 | One-clock pulse when `setting` takes a new value |

## Verification
The tick counter and the armed flag cannot be seen directly, so faults in them show up only in when `setting` moves.
- A wrong counter reload moves the step to a strobe other than the 64th. The bench sees this on the very next look.
- A flag that fails to re-arm leaves a later detent with no step.
- A flag that never latches gives a second step on the following look, 64 strobes later.
- A wrong saturation bound gives a stray `changed` pulse on the first blocked step.

// File: rtl/encsel_pkg.sv
package encsel_pkg;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

    typedef struct packed {
        logic phase;
        logic dir;
    } pins_t;

    function automatic step_e step_of(input pins_t p, input logic armed);
        step_e s;
        s = STEP_NONE;
        if (!p.phase && !armed) begin
            s = p.dir ? STEP_UP : STEP_DOWN;
        end
        return s;
    endfunction

endpackage

// File: rtl/encsel_tick_div.sv
module encsel_tick_div #(
    parameter int TICK_DIV = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic look
);
    localparam int CW = $clog2(TICK_DIV + 1);
    localparam logic [CW-1:0] RELOAD = CW'(TICK_DIV);
    localparam logic [CW-1:0] LAST   = CW'(1);

    logic [CW-1:0] remain;

    assign look = tick && (remain == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= RELOAD;
        end else if (tick) begin
            if (remain == LAST) begin
                remain <= RELOAD;
            end else begin
                remain <= remain - LAST;
            end
        end
    end
endmodule

// File: rtl/encsel_edge_arm.sv
module encsel_edge_arm
    import encsel_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  look,
    input  pins_t pins,
    output step_e step
);
    logic armed;

    always_comb begin
        step = STEP_NONE;
        if (look) begin
            step = step_of(pins, armed);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
        end else if (look) begin
            if (pins.phase) begin
                armed <= 1'b0;
            end else begin
                armed <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/encsel_sat_reg.sv
module encsel_sat_reg
    import encsel_pkg::*;
#(
    parameter int SET_W    = 3,
    parameter int SET_MAX  = 6,
    parameter int SET_INIT = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  step_e            step,
    output logic [SET_W-1:0] value,
    output logic             moved
);
    localparam logic [SET_W-1:0] TOP  = SET_W'(SET_MAX);
    localparam logic [SET_W-1:0] INIT = SET_W'(SET_INIT);
    localparam logic [SET_W-1:0] ONE  = SET_W'(1);

    logic [SET_W-1:0] nxt;
    logic             go;

    always_comb begin
        nxt = value;
        go  = 1'b0;
        unique case (step)
            STEP_UP: begin
                if (value < TOP) begin
                    nxt = value + ONE;
                    go  = 1'b1;
                end
            end
            STEP_DOWN: begin
                if (value != '0) begin
                    nxt = value - ONE;
                    go  = 1'b1;
                end
            end
            default: begin
                nxt = value;
                go  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= INIT;
            moved <= 1'b0;
        end else begin
            value <= nxt;
            moved <= go;
        end
    end
endmodule

// File: rtl/enc_step_select.sv
module enc_step_select
    import encsel_pkg::*;
#(
    parameter int TICK_DIV = 64,
    parameter int SET_W    = 3,
    parameter int SET_MAX  = 6,
    parameter int SET_INIT = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             pin0,
    input  logic             pin1,
    output logic [SET_W-1:0] setting,
    output logic             changed
);
    logic  look_w;
    pins_t pins_w;
    step_e step_w;

    assign pins_w = '{phase: pin0, dir: pin1};

    encsel_tick_div #(.TICK_DIV(TICK_DIV)) u_div (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .look (look_w)
    );

    encsel_edge_arm u_arm (
        .clk  (clk),
        .rst  (rst),
        .look (look_w),
        .pins (pins_w),
        .step (step_w)
    );

    encsel_sat_reg #(
        .SET_W    (SET_W),
        .SET_MAX  (SET_MAX),
        .SET_INIT (SET_INIT)
    ) u_sat (
        .clk   (clk),
        .rst   (rst),
        .step  (step_w),
        .value (setting),
        .moved (changed)
    );
endmodule

// File: rtl/encsel_chk.sv
module encsel_chk #(
    parameter int TICK_DIV = 64,
    parameter int SET_W    = 3,
    parameter int SET_MAX  = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             look,
    input logic [SET_W-1:0] setting,
    input logic             changed
);
    localparam int CW = $clog2(TICK_DIV + 1);

    logic [CW-1:0] seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen <= '0;
        end else if (tick) begin
            seen <= look ? '0 : seen + CW'(1);
        end
    end

    // R9
    setting_range_chk: assert property (@(posedge clk) disable iff (rst)
        setting <= SET_W'(SET_MAX));

    // R7
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        changed |=> !changed);

    // R7
    pulse_match_chk: assert property (@(posedge clk) disable iff (rst)
        changed == (setting != $past(setting)));

    // R2
    quiet_between_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(look) |-> $stable(setting));

    // R2
    look_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        look |-> tick);

    // R8
    look_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        look |-> (seen == CW'(TICK_DIV - 1)));

    // R5
    step_up_chk: assert property (@(posedge clk) disable iff (rst)
        (changed && $past(look) && $past(tick)) |->
            ((setting == $past(setting) + SET_W'(1)) || (setting == $past(setting) - SET_W'(1))));
endmodule

bind enc_step_select encsel_chk #(
    .TICK_DIV (TICK_DIV),
    .SET_W    (SET_W),
    .SET_MAX  (SET_MAX)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .look    (look_w),
    .setting (setting),
    .changed (changed)
);

// File: tb/enc_step_select_test.sv
module enc_step_select_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       pin0 = 1'b1;
    logic       pin1 = 1'b0;
    logic [2:0] setting;
    logic       changed;

    int checks = 0;
    int fails  = 0;
    int mcnt   = 64;
    int mset   = 3;
    bit marm   = 1'b0;
    int expq[$];
    bit prev_chg = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    enc_step_select uut (
        .clk(clk), .rst(rst), .tick(tick), .pin0(pin0), .pin1(pin1),
        .setting(setting), .changed(changed)
    );

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: one strobe, model of the requirements, expected item pushed
    task automatic one_tick(input bit p0, input bit p1, input int gap);
        @(negedge clk);
        pin0 = p0; pin1 = p1; tick = 1'b1;
        if (mcnt == 1) begin
            mcnt = 64;
            if (p0) begin
                marm = 1'b0;
            end else if (!marm) begin
                marm = 1'b1;
                if (p1) begin
                    if (mset < 6) begin mset++; expq.push_back(mset); end
                end else begin
                    if (mset > 0) begin mset--; expq.push_back(mset); end
                end
            end
        end else begin
            mcnt--;
        end
        @(negedge clk);
        tick = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic run_ticks(input int n, input bit p0, input bit p1);
        for (int i = 0; i < n; i++) one_tick(p0, p1, 0);
    endtask

    // Take the look with given pins, then compare
    task automatic look_with(input bit p0, input bit p1, input string req);
        run_ticks(63, 1'b1, 1'b0);
        one_tick(p0, p1, 1);
        check_eq(req, int'(setting), mset);
        check_eq({req, " queue drained"}, expq.size(), 0);
    endtask

    // Monitor
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (changed) begin
                if (prev_chg) begin
                    checks++; fails++;
                    $display("FAIL R7 pulse longer than one clock actual=2 expected=1");
                end
                if (expq.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R7 pulse with no change expected actual=%0d expected=none", setting);
                end else begin
                    check_eq("R5/R6/R7 new value with pulse", int'(setting), expq.pop_front());
                end
            end
            prev_chg = changed;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_eq("R1 setting at reset", int'(setting), 3);
        check_eq("R1 changed at reset", int'(changed), 0);
        rst = 1'b0;

        // R2: 63 strobes with a detent held, nothing happens
        run_ticks(63, 1'b0, 1'b1);
        check_eq("R2 no look before 64th strobe", int'(setting), 3);
        // R2: idle clocks with tick low
        pin0 = 1'b0; repeat (20) @(negedge clk);
        check_eq("R2 idle clocks ignored", int'(setting), 3);
        one_tick(1'b0, 1'b1, 1);
        check_eq("R5 step up on 64th strobe", int'(setting), 4);

        // R4: still low and armed
        run_ticks(63, 1'b0, 1'b1);
        one_tick(1'b0, 1'b1, 1);
        check_eq("R4 armed blocks step", int'(setting), 4);

        // R2: pin0 high only between looks does not re-arm
        run_ticks(63, 1'b1, 1'b1);
        one_tick(1'b0, 1'b1, 1);
        check_eq("R2 unseen high ignored", int'(setting), 4);

        // R3: re-arm
        look_with(1'b1, 1'b1, "R3 rearm no change");
        look_with(1'b0, 1'b1, "R5 up to 5");
        look_with(1'b1, 1'b1, "R3 rearm");
        look_with(1'b0, 1'b1, "R5 up to 6");
        look_with(1'b1, 1'b1, "R3 rearm");
        look_with(1'b0, 1'b1, "R7 blocked at 6");
        check_eq("R9 held at 6", int'(setting), 6);

        for (int k = 0; k < 7; k++) begin
            look_with(1'b1, 1'b0, "R3 rearm");
            look_with(1'b0, 1'b0, "R6 step down");
        end
        check_eq("R6 floor at 0", int'(setting), 0);

        // R8: irregular gaps, look still on 64th strobe
        look_with(1'b1, 1'b0, "R3 rearm");
        for (int i = 0; i < 63; i++) one_tick(1'b0, 1'b1, i % 5);
        check_eq("R8 no step at 63rd irregular strobe", int'(setting), 0);
        one_tick(1'b0, 1'b1, 2);
        check_eq("R8 step at 64th irregular strobe", int'(setting), 1);

        repeat (3) @(negedge clk);
        check_eq("R7 all pulses seen", expq.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule